// File: doc/BRIEF.md
# Staged Multi-Channel Power-On Sequencer

This block sits between the per-channel switch-on requests of a line feed controller and the line drivers. It stops several channels from entering their start-up current-limit phase together. A request that arrives is stored. The block then grants stored requests one at a time, and it issues the next grant only after the channel now starting has left current limiting. When several requests wait, the lowest channel index is served first, whatever order they arrived in. A channel that never leaves current limiting holds up the queue until its request is withdrawn.

All sequencing steps happen on a slow external tick, which is a one-clock enable strobe with a nominal rate of 8 kHz. Withdrawing a request bypasses the tick and switches the channel off on the next clock. A strap input disables sequencing, and the drivers then follow the requests directly. A flag from the thermal supervisor stops new arrivals from being stored. A per-channel overload qualifier reports current limiting only after it has lasted a set number of ticks. With the default of 160 ticks at 8 kHz, that is 20 ms.

Top module: `power_on_sequencer`

## Requirements
- R1: While reset is low, and on the first clock after it, the outputs `grant`, `powering` and `overload` are all zero.
- R2: With sequencing enabled and the reject flag low, a rising request on channel i sets `powering[i]` on the next clock. `grant[i]` stays low until a later tick.
- R3: At most one channel is in its start-up phase at a time. That phase is `powering[i]` and `grant[i]` both high. On a tick when no channel is in that phase, the lowest stored channel is granted and enters the phase.
- R4: The start-up phase of channel i ends on the first tick on which `curLimit[i]` is low. `powering[i]` then falls, `grant[i]` stays high, and the next stored channel is granted no earlier than the following tick. While `curLimit[i]` stays high, no other channel is granted.
- R5: Stored requests are served in ascending channel index, regardless of arrival order.
- R6: Current limiting on a channel that has finished its start-up phase does not delay the granting of other channels.
- R7: Dropping `actReq[i]` clears `grant[i]` and `powering[i]` on the next clock, without waiting for a tick.
- R8: Dropping the request of the channel in its start-up phase ends that phase. The lowest stored channel is granted on the next tick.
- R9: A request that rises while `rejectNew` is high is not stored. It is never granted, even after the flag falls, unless it is withdrawn and raised again. Requests stored before the flag rose stay queued and are served.
- R10: With `seqEnable` low, `grant` equals `actReq` from the previous clock without any tick, and `powering` is zero.
- R11: `overload[i]` rises once `curLimit[i]` has been high on `QUAL_TICKS` consecutive ticks. It falls on the clock after `curLimit[i]` goes low, and the count then starts again from zero.
- R12: With sequencing enabled, a grant bit changes from 0 to 1 only on a clock on which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-clock enable strobe of the slow sequencing tick |
| seqEnable | input | 1 | Strap: 1 = sequencing on, 0 = requests granted directly |
| rejectNew | input | 1 | Thermal supervisor flag: do not store new arrivals |
| actReq | input | NUM_CH | Per-channel activation request, level, 1 = on |
| curLimit | input | NUM_CH | Per-channel raw current-limit indication |
| grant | output | NUM_CH | Per-channel driver enable |
| powering | output | NUM_CH | Per-channel flag: request stored or start-up phase running |
| overload | output | NUM_CH | Per-channel qualified overload flag |

## Verification
On every clock the assertions check four rules: at most one channel is in its start-up phase, a withdrawn request leaves no grant or powering flag behind, no grant appears off a tick while sequencing is on, and a qualified overload never outlives its raw limit indication. The bypass rule that `powering` stays zero is also checked continuously. Only the bench scenarios can show the service order and the stall behind a channel that keeps limiting. The same holds for the rejection of arrivals while stored requests survive, and for the exact tick count of the overload qualifier. To cover the order, the bench sweeps every non-empty set of simultaneous requests and compares the grants against ascending index order.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Width of a channel index carried in the strobe struct (up to 32 channels).
  localparam int SEQ_IDX_W = 5;

  typedef struct packed {
    logic                 bypass;    // sequencing disabled, grants follow requests
    logic                 launch;    // grant the chosen stored channel
    logic [SEQ_IDX_W-1:0] launchIdx; // which channel to launch
    logic                 endPhase;  // close the running start-up phase
  } seqStrobeT;
endpackage

// File: rtl/ovl_qualifier.sv
module ovl_qualifier #(
  parameter int QUAL_TICKS = 160
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic rawLimit,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (!rawLimit)     cnt <= '0;
    else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign qualified = (cnt == LIMIT);
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              tick,
  input  logic              seqEnable,
  input  logic [NUM_CH-1:0] pendMask,
  input  logic [NUM_CH-1:0] activeMask,
  input  logic [NUM_CH-1:0] curLimit,
  output seqStrobeT         strobe
);
  logic                 phaseBusy;
  logic                 activeLimited;
  logic                 anyPending;
  logic [SEQ_IDX_W-1:0] lowIdx;

  assign phaseBusy     = |activeMask;
  assign activeLimited = |(activeMask & curLimit);
  assign anyPending    = |pendMask;

  // Lowest stored index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendMask[i]) lowIdx = SEQ_IDX_W'(i);
    end
  end

  always_comb begin
    strobe.bypass    = ~seqEnable;
    strobe.launch    = seqEnable & tick & ~phaseBusy & anyPending;
    strobe.launchIdx = lowIdx;
    strobe.endPhase  = seqEnable & tick & phaseBusy & ~activeLimited;
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] actReq,
  input  logic              rejectNew,
  input  seqStrobeT         strobe,
  output logic [NUM_CH-1:0] pendMask,
  output logic [NUM_CH-1:0] activeMask,
  output logic [NUM_CH-1:0] grantMask
);
  logic [NUM_CH-1:0] reqPrev;
  logic [NUM_CH-1:0] arrivals;
  logic [NUM_CH-1:0] launchOh;
  logic [NUM_CH-1:0] pendNext;
  logic [NUM_CH-1:0] activeNext;
  logic [NUM_CH-1:0] grantNext;

  assign arrivals = actReq & ~reqPrev;

  for (genvar g = 0; g < NUM_CH; g++) begin : gLaunch
    assign launchOh[g] = strobe.launch && (strobe.launchIdx == SEQ_IDX_W'(g));
  end

  // A withdrawn request is masked last, so it wins over storage and launch.
  always_comb begin
    if (strobe.bypass) begin
      pendNext   = '0;
      activeNext = '0;
      grantNext  = actReq;
    end else begin
      pendNext   = (pendMask | (arrivals & {NUM_CH{~rejectNew}})) & ~launchOh & actReq;
      activeNext = ((strobe.endPhase ? '0 : activeMask) | launchOh) & actReq;
      grantNext  = (grantMask | launchOh) & actReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev    <= '0;
      pendMask   <= '0;
      activeMask <= '0;
      grantMask  <= '0;
    end else begin
      reqPrev    <= actReq;
      pendMask   <= pendNext;
      activeMask <= activeNext;
      grantMask  <= grantNext;
    end
  end
endmodule

// File: rtl/power_on_sequencer.sv
module power_on_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int QUAL_TICKS = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              seqEnable,
  input  logic              rejectNew,
  input  logic [NUM_CH-1:0] actReq,
  input  logic [NUM_CH-1:0] curLimit,
  output logic [NUM_CH-1:0] grant,
  output logic [NUM_CH-1:0] powering,
  output logic [NUM_CH-1:0] overload
);
  seqStrobeT         strobe;
  logic [NUM_CH-1:0] pendMask;
  logic [NUM_CH-1:0] activeMask;
  logic [NUM_CH-1:0] grantMask;

  seq_control #(.NUM_CH(NUM_CH)) i_control (
    .tick       (tick),
    .seqEnable  (seqEnable),
    .pendMask   (pendMask),
    .activeMask (activeMask),
    .curLimit   (curLimit),
    .strobe     (strobe)
  );

  seq_datapath #(.NUM_CH(NUM_CH)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .actReq     (actReq),
    .rejectNew  (rejectNew),
    .strobe     (strobe),
    .pendMask   (pendMask),
    .activeMask (activeMask),
    .grantMask  (grantMask)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gQual
    ovl_qualifier #(.QUAL_TICKS(QUAL_TICKS)) i_qual (
      .clk       (clk),
      .rstN      (rstN),
      .tick      (tick),
      .rawLimit  (curLimit[g]),
      .qualified (overload[g])
    );
  end

  assign grant    = grantMask;
  assign powering = pendMask | activeMask;
endmodule

// File: rtl/power_on_sequencer_chk.sv
module power_on_sequencer_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              seqEnable,
  input logic [NUM_CH-1:0] actReq,
  input logic [NUM_CH-1:0] curLimit,
  input logic [NUM_CH-1:0] grant,
  input logic [NUM_CH-1:0] powering,
  input logic [NUM_CH-1:0] overload
);
  assert_single_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(powering & grant));

  assert_withdraw_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((grant | powering) & ~$past(actReq)) == '0));

  assert_bypass_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !seqEnable |=> (powering == '0));

  assert_grant_on_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    (seqEnable && !tick) |=> ((grant & ~$past(grant)) == '0));

  assert_overload_needs_limit_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((overload & ~$past(curLimit)) == '0));
endmodule

bind power_on_sequencer power_on_sequencer_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .seqEnable (seqEnable),
  .actReq    (actReq),
  .curLimit  (curLimit),
  .grant     (grant),
  .powering  (powering),
  .overload  (overload)
);

// File: tb/test_power_on_sequencer.sv
module test_power_on_sequencer;
  localparam int NUM_CH     = 4;
  localparam int QUAL_TICKS = 160;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              seqEnable = 1'b1;
  logic              rejectNew = 1'b0;
  logic [NUM_CH-1:0] actReq = '0;
  logic [NUM_CH-1:0] curLimit = '0;
  logic [NUM_CH-1:0] grant;
  logic [NUM_CH-1:0] powering;
  logic [NUM_CH-1:0] overload;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  power_on_sequencer #(.NUM_CH(NUM_CH), .QUAL_TICKS(QUAL_TICKS)) i_power_on_sequencer (
    .clk(clk), .rstN(rstN), .tick(tick), .seqEnable(seqEnable), .rejectNew(rejectNew),
    .actReq(actReq), .curLimit(curLimit), .grant(grant), .powering(powering),
    .overload(overload)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickPulse();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] rem;
    logic [NUM_CH-1:0] low;
    logic [NUM_CH-1:0] expGrant;

    cyc(3);
    check("R1 grant in reset", grant, 0);
    check("R1 powering in reset", powering, 0);
    rstN = 1'b1;
    cyc(1);
    check("R1 overload after reset", overload, 0);
    check("R1 grant after reset", grant, 0);

    // Channel 2 starts, then 1, 3, 0 arrive while it limits.
    actReq = 4'b0100; cyc(1);
    check("R2 stored", powering, 4'b0100);
    check("R2 no grant before tick", grant, 0);
    cyc(5);
    check("R12 no grant without tick", grant, 0);
    tickPulse();
    check("R3 first grant", grant, 4'b0100);
    curLimit = 4'b0100;
    actReq = 4'b0110; cyc(1);
    actReq = 4'b1110; cyc(1);
    actReq = 4'b1111; cyc(1);
    check("R5 all stored", powering, 4'b1111);
    tickPulse();
    check("R4 stall while limiting", grant, 4'b0100);
    curLimit = 4'b0000;
    tickPulse();
    check("R4 phase end", powering, 4'b1011);
    check("R4 no grant same tick", grant, 4'b0100);
    tickPulse(); check("R5 ch0 first", grant, 4'b0101);
    tickPulse(); check("R4 ch0 done", powering, 4'b1010);
    tickPulse(); check("R5 ch1 second", grant, 4'b0111);
    tickPulse();
    tickPulse(); check("R5 ch3 last", grant, 4'b1111);
    tickPulse(); check("R4 queue empty", powering, 4'b0000);

    // Later limiting on finished channels, withdrawal and abort.
    curLimit = 4'b1111;
    actReq = 4'b1101; cyc(1);
    check("R7 withdraw immediate", grant, 4'b1101);
    actReq = 4'b1111; cyc(1);
    tickPulse();
    check("R6 finished limiting ignored", grant, 4'b1111);
    tickPulse();
    check("R4 ch1 still starting", powering, 4'b0010);
    actReq = 4'b1011; cyc(1);
    actReq = 4'b1111; cyc(1);
    tickPulse();
    check("R4 ch2 waits behind ch1", grant, 4'b1011);
    check("R4 ch2 stored", powering, 4'b0110);
    actReq = 4'b1101; cyc(1);
    check("R8 abort grant", grant, 4'b1001);
    check("R8 abort powering", powering, 4'b0100);
    tickPulse();
    check("R8 next launched", grant, 4'b1101);
    actReq = 4'b0000; curLimit = 4'b0000; cyc(1);
    check("R7 all withdrawn", grant | powering, 0);

    // Reject flag.
    rejectNew = 1'b1;
    actReq = 4'b0001; cyc(1);
    check("R9 arrival not stored", powering, 0);
    tickPulse();
    check("R9 not granted while flagged", grant, 0);
    rejectNew = 1'b0;
    tickPulse(); tickPulse();
    check("R9 not granted after flag", grant, 0);
    actReq = 4'b0000; cyc(1);
    curLimit = 4'b1000;
    actReq = 4'b1000; cyc(1);
    tickPulse();
    actReq = 4'b1010; cyc(1);
    rejectNew = 1'b1;
    actReq = 4'b1110; cyc(1);
    check("R9 stored kept, new dropped", powering, 4'b1010);
    curLimit = 4'b0000;
    tickPulse(); tickPulse();
    check("R9 stored request served", grant, 4'b1010);
    check("R9 rejected never pending", powering, 4'b0010);
    rejectNew = 1'b0;
    actReq = 4'b0000; cyc(1);
    tickPulse();

    // Exhaustive sweep of simultaneous request sets.
    for (int m = 1; m < (1 << NUM_CH); m++) begin
      actReq = NUM_CH'(m); cyc(1);
      check("R2 sweep stored", powering, m);
      rem = NUM_CH'(m);
      expGrant = '0;
      while (rem != '0) begin
        low = rem & (~rem + 1'b1);
        tickPulse();
        expGrant |= low;
        check("R5 sweep order", grant, expGrant);
        tickPulse();
        rem &= ~low;
        check("R4 sweep phase end", powering, rem);
      end
      actReq = '0; cyc(1);
      check("R7 sweep release", grant, 0);
    end

    // Bypass strap.
    seqEnable = 1'b0;
    actReq = 4'b1010; cyc(1);
    check("R10 bypass grant", grant, 4'b1010);
    check("R10 bypass powering", powering, 0);
    actReq = 4'b1000; cyc(1);
    check("R10 bypass follow", grant, 4'b1000);
    actReq = '0; cyc(1);
    seqEnable = 1'b1;

    // Overload qualifier.
    curLimit = 4'b0100;
    for (int k = 0; k < QUAL_TICKS - 1; k++) tickPulse();
    check("R11 one tick short", overload, 0);
    tickPulse();
    check("R11 qualified", overload, 4'b0100);
    curLimit = 4'b0000; cyc(1);
    check("R11 clears", overload, 0);
    curLimit = 4'b0100;
    for (int k = 0; k < 100; k++) tickPulse();
    curLimit = 4'b0000; cyc(1);
    curLimit = 4'b0100;
    for (int k = 0; k < 100; k++) tickPulse();
    check("R11 count restarts", overload, 0);
    curLimit = 4'b0000;

    // Reset with a driver on.
    actReq = 4'b0001; cyc(1);
    tickPulse();
    check("R3 grant before reset", grant, 4'b0001);
    rstN = 1'b0; cyc(1);
    check("R1 reset clears grant", grant | powering | overload, 0);
    rstN = 1'b1;
    actReq = '0;
    cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule